// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This execute-stage unit decides whether a trap instruction of a 64-bit RISC core takes effect. It receives the already decoded fields of one instruction: the primary opcode, the extended opcode, the 5-bit condition mask and the 16-bit immediate. It also receives two 64-bit operand values and the address of the instruction. It compares operand A against a second value, signed and unsigned at the same time. The second value is either operand B or the sign-extended immediate. The comparison runs at word or doubleword width. The trap fires when any condition selected by the mask holds.

When the trap fires, the unit requests a program interrupt with its vector address and the trap flag for the saved machine status. It keeps the next program counter at the faulting instruction. Otherwise the next program counter is the instruction address plus four. No register is written in either case. Results appear one clock after a valid strobe. The register file, the interrupt delivery and the system-call path live elsewhere.

Top module: `cond_trap_unit`

## Requirements
- R1: Mask bit 4 (value 16) enables signed less-than, bit 3 (8) signed greater-than, bit 2 (4) equality, bit 1 (2) unsigned less-than and bit 0 (1) unsigned greater-than. A trap fires when at least one enabled condition holds for A compared with the second operand.
- R2: Mask 0 never traps. Mask 31 traps for every operand pair in all four trap forms.
- R3: In the immediate forms, the second operand is `imm16` sign-extended to 64 bits and `opnd_b` is ignored. In the register forms, the second operand is `opnd_b` and `imm16` is ignored.
- R4: The doubleword forms compare all 64 bits. The word forms take the low 32 bits of each operand, sign-extended for the signed conditions and zero-extended for the unsigned ones, so the upper 32 bits have no effect.
- R5: The recognised forms are: primary 2 (doubleword immediate), primary 3 (word immediate), and primary 31 with extended 68 (doubleword register) or extended 4 (word register). The extended opcode is ignored for primaries 2 and 3. Any other combination gives `insn_ok` = 0 and no trap.
- R6: On a trap, `next_pc` equals the instruction's `cur_pc`. Otherwise `next_pc` equals `cur_pc` + 4.
- R7: On a trap, `trap_vector` is 0x700 and `trap_flag` is 1. Without a trap, both are 0.
- R8: The outputs are registered. `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` = 1. After a cycle without `in_valid`, `trap_req` is 0.
- R9: Synchronous reset clears `out_valid`, `insn_ok`, `trap_req`, `trap_flag`, `trap_vector` and `next_pc` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction strobe |
| op_primary | input | 6 | Primary opcode |
| op_ext | input | 10 | Extended opcode (register forms) |
| to_mask | input | 5 | Trap condition mask |
| imm16 | input | 16 | Signed immediate |
| opnd_a | input | 64 | Operand A value |
| opnd_b | input | 64 | Operand B value (register forms) |
| cur_pc | input | 64 | Address of the instruction |
| out_valid | output | 1 | Result valid |
| insn_ok | output | 1 | Instruction was a recognised trap form |
| trap_req | output | 1 | Program-interrupt request |
| trap_flag | output | 1 | Trap bit for the saved machine status |
| trap_vector | output | 64 | Interrupt vector address |
| next_pc | output | 64 | Next program counter |

## Verification
A wrong width or extension choice shows in the very next result. It makes `trap_req` disagree with the expected condition for operands that differ only above bit 31, or only in a sign bit. A wrong pick between the immediate and the register operand shows the same way: `trap_req` disagrees with the value expected from the operand that should have been used. Because every result is registered exactly once, a stale or misrouted register shows up one cycle after the strobe. It appears as a `next_pc` off by four, a vector or flag that disagrees with `trap_req`, or an `out_valid` outside the cycle that follows the strobe.

// File: rtl/cond_trap_unit.sv
module cond_trap_unit #(
  parameter int XLEN = 64,
  parameter int IMMW = 16,
  parameter logic [63:0] TRAP_VEC = 64'h700,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [5:0]      op_primary,
  input  logic [9:0]      op_ext,
  input  logic [4:0]      to_mask,
  input  logic [IMMW-1:0] imm16,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [XLEN-1:0] cur_pc,
  output logic            out_valid,
  output logic            insn_ok,
  output logic            trap_req,
  output logic            trap_flag,
  output logic [XLEN-1:0] trap_vector,
  output logic [XLEN-1:0] next_pc
);
  localparam int WLEN = XLEN / 2;
  localparam logic [5:0] OP_DIMM = 6'd2;
  localparam logic [5:0] OP_WIMM = 6'd3;
  localparam logic [5:0] OP_XGRP = 6'd31;
  localparam logic [9:0] XO_WREG = 10'd4;
  localparam logic [9:0] XO_DREG = 10'd68;

  logic is_imm, is_reg, is_word, legal;
  assign is_imm  = (op_primary == OP_DIMM) || (op_primary == OP_WIMM);
  assign is_reg  = (op_primary == OP_XGRP) && ((op_ext == XO_WREG) || (op_ext == XO_DREG));
  assign legal   = is_imm || is_reg;
  assign is_word = (op_primary == OP_WIMM) || ((op_primary == OP_XGRP) && (op_ext == XO_WREG));

  logic [XLEN-1:0] b_sel, a_s, b_s, a_u, b_u;
  assign b_sel = is_imm ? {{(XLEN-IMMW){imm16[IMMW-1]}}, imm16} : opnd_b;
  assign a_s = is_word ? {{WLEN{opnd_a[WLEN-1]}}, opnd_a[WLEN-1:0]} : opnd_a;
  assign b_s = is_word ? {{WLEN{b_sel[WLEN-1]}},  b_sel[WLEN-1:0]}  : b_sel;
  assign a_u = is_word ? {{WLEN{1'b0}}, opnd_a[WLEN-1:0]} : opnd_a;
  assign b_u = is_word ? {{WLEN{1'b0}}, b_sel[WLEN-1:0]}  : b_sel;

  logic [4:0] cond;
  assign cond = { $signed(a_s) < $signed(b_s),
                  $signed(a_s) > $signed(b_s),
                  a_u == b_u,
                  a_u < b_u,
                  a_u > b_u };

  logic fire;
  assign fire = legal && |(to_mask & cond);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      insn_ok     <= 1'b0;
      trap_req    <= 1'b0;
      trap_flag   <= 1'b0;
      trap_vector <= '0;
      next_pc     <= '0;
    end else if (in_valid) begin
      out_valid   <= 1'b1;
      insn_ok     <= legal;
      trap_req    <= fire;
      trap_flag   <= fire;
      trap_vector <= fire ? TRAP_VEC[XLEN-1:0] : '0;
      next_pc     <= fire ? cur_pc : cur_pc + XLEN'(PC_STEP);
    end else begin
      out_valid   <= 1'b0;
      trap_req    <= 1'b0;
      trap_flag   <= 1'b0;
      trap_vector <= '0;
    end
  end
endmodule

module cond_trap_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [5:0]  op_primary,
  input logic [4:0]  to_mask,
  input logic [63:0] cur_pc,
  input logic        out_valid,
  input logic        insn_ok,
  input logic        trap_req,
  input logic        trap_flag,
  input logic [63:0] trap_vector,
  input logic [63:0] next_pc
);
  assert_mask_zero_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && to_mask == 5'd0 |=> !trap_req);
  assert_mask_all_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && to_mask == 5'd31 && op_primary == 6'd2 |=> trap_req);
  assert_illegal_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && !insn_ok |-> !trap_req);
  assert_trap_pc_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (trap_req ? next_pc == $past(cur_pc) : next_pc == $past(cur_pc) + 64'd4));
  assert_vector_R7: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> trap_flag && trap_vector == 64'h700);
  assert_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !trap_req |-> !trap_flag && trap_vector == 64'd0);
  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !trap_req);
endmodule

bind cond_trap_unit cond_trap_unit_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_primary(op_primary),
  .to_mask(to_mask), .cur_pc(cur_pc), .out_valid(out_valid), .insn_ok(insn_ok),
  .trap_req(trap_req), .trap_flag(trap_flag), .trap_vector(trap_vector),
  .next_pc(next_pc)
);

// File: tb/cond_trap_unit_test.sv
`timescale 1ns/1ps
module cond_trap_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  op_primary = '0;
  logic [9:0]  op_ext = '0;
  logic [4:0]  to_mask = '0;
  logic [15:0] imm16 = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0, cur_pc = '0;
  logic        out_valid, insn_ok, trap_req, trap_flag;
  logic [63:0] trap_vector, next_pc;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cond_trap_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_primary(op_primary),
    .op_ext(op_ext), .to_mask(to_mask), .imm16(imm16), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .cur_pc(cur_pc), .out_valid(out_valid), .insn_ok(insn_ok),
    .trap_req(trap_req), .trap_flag(trap_flag), .trap_vector(trap_vector),
    .next_pc(next_pc)
  );

  // forms: 0 dword imm, 1 word imm, 2 dword reg, 3 word reg, 4 bad ext, 5 bad primary
  localparam int F_DI = 0, F_WI = 1, F_DR = 2, F_WR = 3, F_BX = 4, F_BP = 5;

  function automatic bit model_fire(int form, logic [4:0] m, logic [63:0] a,
                                    logic [63:0] b, logic [15:0] im);
    logic [63:0] bv;
    bit slt, sgt, eq, ult, ugt;
    if (form >= F_BX) return 1'b0;
    bv = (form == F_DI || form == F_WI) ? {{48{im[15]}}, im} : b;
    if (form == F_WI || form == F_WR) begin
      slt = $signed(a[31:0]) < $signed(bv[31:0]);
      sgt = $signed(a[31:0]) > $signed(bv[31:0]);
      eq  = a[31:0] == bv[31:0];
      ult = a[31:0] < bv[31:0];
      ugt = a[31:0] > bv[31:0];
    end else begin
      slt = $signed(a) < $signed(bv);
      sgt = $signed(a) > $signed(bv);
      eq  = a == bv;
      ult = a < bv;
      ugt = a > bv;
    end
    return (m[4] & slt) | (m[3] & sgt) | (m[2] & eq) | (m[1] & ult) | (m[0] & ugt);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(int form, logic [4:0] m, logic [63:0] a, logic [63:0] b,
                          logic [15:0] im, string req);
    bit ef;
    logic [63:0] pc;
    pc = {32'h0, $urandom} & ~64'h3;
    @(negedge clk);
    case (form)
      F_DI: begin op_primary = 6'd2; op_ext = 10'($urandom); end
      F_WI: begin op_primary = 6'd3; op_ext = 10'($urandom); end
      F_DR: begin op_primary = 6'd31; op_ext = 10'd68; end
      F_WR: begin op_primary = 6'd31; op_ext = 10'd4; end
      F_BX: begin op_primary = 6'd31; op_ext = 10'd5; end
      default: begin op_primary = 6'd4; op_ext = 10'd68; end
    endcase
    to_mask = m; opnd_a = a; opnd_b = b; imm16 = im; cur_pc = pc; in_valid = 1'b1;
    ef = model_fire(form, m, a, b, im);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R8 out_valid", 64'(out_valid), 64'd1);
    chk(insn_ok === (form < F_BX), "R5 insn_ok", 64'(insn_ok), 64'(form < F_BX));
    chk(trap_req === ef, req, 64'(trap_req), 64'(ef));
    chk(next_pc === (ef ? pc : pc + 64'd4), "R6 next_pc", next_pc, ef ? pc : pc + 64'd4);
    chk(trap_vector === (ef ? 64'h700 : 64'h0), "R7 vector", trap_vector, ef ? 64'h700 : 64'h0);
    chk(trap_flag === ef, "R7 flag", 64'(trap_flag), 64'(ef));
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] masks [11] = '{5'd16, 5'd8, 5'd4, 5'd24, 5'd20, 5'd12, 5'd2, 5'd1, 5'd5, 5'd6, 5'd31};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(out_valid === 1'b0 && trap_req === 1'b0 && trap_flag === 1'b0,
        "R9 reset ctl", {61'd0, out_valid, trap_req, trap_flag}, 64'd0);
    chk(trap_vector === 64'd0 && next_pc === 64'd0 && insn_ok === 1'b0,
        "R9 reset data", next_pc | trap_vector, 64'd0);
    rst = 1'b0;

    // R1 R2 R3: standard masks against boundary operands
    foreach (masks[i]) begin
      run_case(F_DI, masks[i], 64'd5, 64'hDEAD, 16'd5, "R1 equal imm");
      run_case(F_DI, masks[i], 64'h7FFF, 64'd0, 16'h7FFF, "R3 imm 7fff");
      run_case(F_DI, masks[i], 64'hFFFF_FFFF_FFFF_8000, 64'd0, 16'h8000, "R3 imm 8000 eq");
      run_case(F_DI, masks[i], 64'h8000, 64'd0, 16'h8000, "R3 imm 8000 ext");
      run_case(F_DR, masks[i], 64'h8000_0000_0000_0000, 64'd0, 16'h1234, "R1 sign bit dword");
      run_case(F_DR, masks[i], 64'd0, 64'h8000_0000_0000_0000, 16'h0, "R1 sign bit swap");
      run_case(F_WR, masks[i], 64'h0000_0000_8000_0000, 64'd0, 16'h0, "R4 word sign");
      run_case(F_WI, masks[i], 64'h1_0000_0005, 64'd0, 16'd5, "R4 word high ignored");
      run_case(F_DI, masks[i], 64'h1_0000_0005, 64'd0, 16'd5, "R4 dword high counts");
    end
    // R2 mask 0 and 31 extremes
    run_case(F_DR, 5'd0, 64'd7, 64'd7, 16'd0, "R2 mask zero");
    run_case(F_WI, 5'd31, 64'd1, 64'd0, 16'd1, "R2 mask all");
    // R5 unrecognised forms
    run_case(F_BX, 5'd31, 64'd1, 64'd1, 16'd1, "R5 bad ext");
    run_case(F_BP, 5'd31, 64'd1, 64'd1, 16'd1, "R5 bad primary");
    // R8 idle cycle after a trap
    run_case(F_DI, 5'd31, 64'd0, 64'd0, 16'd0, "R8 trap before idle");
    @(negedge clk);
    chk(out_valid === 1'b0 && trap_req === 1'b0, "R8 idle",
        {62'd0, out_valid, trap_req}, 64'd0);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int f;
      logic [63:0] a, b;
      logic [15:0] im;
      f = int'($urandom_range(0, 5));
      im = 16'($urandom);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      case ($urandom_range(0, 3))
        0: b = a;
        1: a = {{48{im[15]}}, im};
        2: b = {a[63:32] ^ 32'h8000_0000, a[31:0]};
        default: ;
      endcase
      run_case(f, 5'($urandom), a, b, im, "R1 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule